// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

A single DMA channel that moves data between a source and a target address. Software loads the channel through a small register port: a control/status word, a next-descriptor pointer, the source and target addresses and a command word. Setting the run bit starts the channel. In chained mode the channel reads a four-word descriptor from memory: next pointer, source, target, command. It then moves the byte count that the command names and follows the next pointer until it reaches a descriptor whose pointer has its stop flag set. In direct mode the channel skips the fetch and runs once from the values software has written.

Each transfer unit is a read from the source address followed by a write to the target address over a simple request/acknowledge memory port. The command word selects the unit width, the burst size, whether each address advances, and whether a peripheral request paces every burst. Start, end and bus-error events latch into status bits that software clears by writing ones. A single interrupt line combines these events with an optional stop interrupt.

Top module: `dmach_engine`

## Requirements
- R1: After reset the control/status word reads 0x0000_0008: only the stopped bit (bit 3) is set. The interrupt is low and no memory request is made while the channel is stopped.
- R2: Setting run (bit 31) with fetching enabled and a next pointer whose stop flag (bit 0) is clear starts a fetch. The channel reads the words at base+0, +4, +8 and +12 (base = pointer with bits 3:0 zeroed) into next, source, target and command, in that order. It follows the chain until a descriptor whose next word has bit 0 set completes, then clears run and sets stopped.
- R3: Each unit reads the source and then writes that word to the target. The width code in command bits 15:14 gives 1 byte for 1, 2 bytes for 2, and 4 bytes for 3 or 0. The unit is the width, or 2 or 1 bytes when fewer bytes remain. The remaining count starts at command bits 12:0. The source advances by the unit when command bit 31 is set, and the target when bit 30 is set. mem_size gives log2 of the unit. A zero length moves no data.
- R4: When command bit 29 or bit 28 is set, every burst waits for dreq. The burst size in bits 17:16 is 16 bytes for 2, 32 bytes for 3, and 8 bytes for 1 or 0. With both bits clear the channel runs without waiting.
- R5: At descriptor start, status bit 1 latches if command bit 22 is set. At descriptor end, status bit 2 latches if command bit 21 is set. Writing a one to status bits 2:0 clears them.
- R6: irq is high when status bit 0, 1 or 2 is set, or when the channel is stopped and the stop-interrupt enable (bit 29) is set.
- R7: With bit 30 set at start, the channel runs one transfer from the source, target and command registers without fetching, then clears run and stops.
- R8: An error on any memory acknowledge sets status bit 0, clears run and returns the channel to stopped.
- R9: Writing run as 0 halts the channel: it finishes an outstanding memory access, then stops. A raised request holds its address and direction until acknowledged.
- R10: Writes to the next, source, target and command registers (addresses 1 to 4) are ignored unless the channel is stopped with run clear. Reads return the live values.
- R11: Setting run while the next pointer has bit 0 set makes no memory access; run clears again.
- R12: Control/status bit 8 shows dreq live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: 0 control/status, 1 next, 2 source, 3 target, 4 command |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_size | output | 2 | log2 of bytes in this access |
| mem_ack | input | 1 | Access acknowledge |
| mem_err | input | 1 | Error response, valid with mem_ack |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| dreq | input | 1 | Peripheral request for flow-paced bursts |
| irq | output | 1 | Interrupt |

## Verification
The hardest state to reach is a channel that is running but parked at a burst boundary, because a memory-to-memory transfer passes through that point in a single cycle. The bench holds dreq low on a flow-paced descriptor, so the channel stays at the start of its first burst for as long as needed. From there it writes descriptor registers that must be ignored, reads the live request bit, and clears run to show an orderly halt. Bus errors come from a memory model that answers with an error for addresses above a fixed boundary.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
    parameter int DM_AW    = 32;
    parameter int DM_LEN_W = 13;
    parameter int DM_CNT_W = 6;

    localparam int CSR_RUN    = 31;
    localparam int CSR_NODESC = 30;
    localparam int CSR_STOPEN = 29;

    localparam logic [2:0] A_CSR = 3'd0;
    localparam logic [2:0] A_NXT = 3'd1;
    localparam logic [2:0] A_SRC = 3'd2;
    localparam logic [2:0] A_TGT = 3'd3;
    localparam logic [2:0] A_CMD = 3'd4;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_LAUNCH, S_WAIT, S_RD, S_WR, S_FINISH
    } dm_state_e;

    typedef struct packed {
        dm_state_e             state;
        logic [1:0]            widx;
        logic                  run;
        logic                  nodesc;
        logic                  stopirq;
        logic                  end_st;
        logic                  start_st;
        logic                  buserr;
        logic [DM_AW-1:0]      base;
        logic [DM_AW-1:0]      nxt;
        logic [DM_AW-1:0]      src;
        logic [DM_AW-1:0]      tgt;
        logic [DM_AW-1:0]      cmd;
        logic [DM_AW-1:0]      data;
        logic [DM_LEN_W-1:0]   len;
        logic [DM_CNT_W-1:0]   burst;
    } dm_regs_t;
endpackage

// File: rtl/dmach_cmd_decode.sv
module dmach_cmd_decode #(
    parameter int LEN_W = 13,
    parameter int CNT_W = 6
) (
    input  logic [1:0]       width_code,
    input  logic [1:0]       burst_code,
    input  logic [LEN_W-1:0] remain,
    output logic [CNT_W-1:0] unit_bytes,
    output logic [1:0]       unit_size,
    output logic [CNT_W-1:0] burst_bytes
);
    logic [CNT_W-1:0] width_bytes;

    always_comb begin
        case (width_code)
            2'd1:    width_bytes = CNT_W'(1);
            2'd2:    width_bytes = CNT_W'(2);
            default: width_bytes = CNT_W'(4);
        endcase
        case (burst_code)
            2'd2:    burst_bytes = CNT_W'(16);
            2'd3:    burst_bytes = CNT_W'(32);
            default: burst_bytes = CNT_W'(8);
        endcase
        if (remain >= LEN_W'(width_bytes))
            unit_bytes = width_bytes;
        else if (remain >= LEN_W'(2))
            unit_bytes = CNT_W'(2);
        else
            unit_bytes = CNT_W'(1);
        case (unit_bytes)
            CNT_W'(4): unit_size = 2'd2;
            CNT_W'(2): unit_size = 2'd1;
            default:   unit_size = 2'd0;
        endcase
    end
endmodule

// File: rtl/dmach_irq_gen.sv
module dmach_irq_gen (
    input  logic end_st,
    input  logic start_st,
    input  logic buserr,
    input  logic stopped,
    input  logic stop_en,
    output logic irq
);
    always_comb begin
        irq = end_st | start_st | buserr | (stopped & stop_en);
    end
endmodule

// File: rtl/dmach_reg_read.sv
module dmach_reg_read #(
    parameter int AW = 32
) (
    input  logic [2:0]    sel,
    input  logic          run,
    input  logic          nodesc,
    input  logic          stop_en,
    input  logic          dreq,
    input  logic          stopped,
    input  logic          end_st,
    input  logic          start_st,
    input  logic          buserr,
    input  logic [AW-1:0] nxt,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] tgt,
    input  logic [AW-1:0] cmd,
    output logic [AW-1:0] rdata
);
    logic [31:0] csr_word;

    always_comb begin
        csr_word = {run, nodesc, stop_en, 20'd0, dreq, 4'd0,
                    stopped, end_st, start_st, buserr};
        case (sel)
            3'd0:    rdata = AW'(csr_word);
            3'd1:    rdata = nxt;
            3'd2:    rdata = src;
            3'd3:    rdata = tgt;
            3'd4:    rdata = cmd;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmach_engine.sv
module dmach_engine
    import dmach_pkg::*;
#(
    parameter int AW    = DM_AW,
    parameter int LEN_W = DM_LEN_W,
    parameter int CNT_W = DM_CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [31:0]   mem_addr,
    output logic [31:0]   mem_wdata,
    output logic [1:0]    mem_size,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic [31:0]   mem_rdata,
    input  logic          dreq,
    output logic          irq
);
    localparam int WORD_B = 4;

    dm_regs_t q, n;

    logic [CNT_W-1:0] unit_bytes, burst_bytes;
    logic [1:0]       unit_size;
    logic             stopped, flow_on, inc_src, inc_tgt, start_en, end_en;
    logic [LEN_W-1:0] len_after;
    logic [CNT_W-1:0] burst_after;

    assign stopped  = (q.state == S_IDLE);
    assign flow_on  = q.cmd[29] | q.cmd[28];
    assign inc_src  = q.cmd[31];
    assign inc_tgt  = q.cmd[30];
    assign start_en = q.cmd[22];
    assign end_en   = q.cmd[21];

    dmach_cmd_decode #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_decode (
        .width_code (q.cmd[15:14]),
        .burst_code (q.cmd[17:16]),
        .remain     (q.len),
        .unit_bytes (unit_bytes),
        .unit_size  (unit_size),
        .burst_bytes(burst_bytes)
    );

    dmach_irq_gen u_irq (
        .end_st  (q.end_st),
        .start_st(q.start_st),
        .buserr  (q.buserr),
        .stopped (stopped),
        .stop_en (q.stopirq),
        .irq     (irq)
    );

    dmach_reg_read #(.AW(AW)) u_rd (
        .sel     (cfg_addr),
        .run     (q.run),
        .nodesc  (q.nodesc),
        .stop_en (q.stopirq),
        .dreq    (dreq),
        .stopped (stopped),
        .end_st  (q.end_st),
        .start_st(q.start_st),
        .buserr  (q.buserr),
        .nxt     (q.nxt),
        .src     (q.src),
        .tgt     (q.tgt),
        .cmd     (q.cmd),
        .rdata   (cfg_rdata)
    );

    assign len_after   = q.len - LEN_W'(unit_bytes);
    assign burst_after = q.burst + unit_bytes;

    always_comb begin
        n         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.src;
        mem_wdata = q.data;
        mem_size  = 2'd2;

        // status bits cleared by writing ones
        if (cfg_we && cfg_addr == A_CSR) begin
            if (cfg_wdata[0]) n.buserr   = 1'b0;
            if (cfg_wdata[1]) n.start_st = 1'b0;
            if (cfg_wdata[2]) n.end_st   = 1'b0;
        end

        case (q.state)
            S_IDLE: begin
                if (q.run) begin
                    if (q.nodesc) begin
                        n.len   = q.cmd[LEN_W-1:0];
                        n.state = S_LAUNCH;
                    end else if (q.nxt[0]) begin
                        n.run = 1'b0;
                    end else begin
                        n.base  = {q.nxt[AW-1:4], 4'h0};
                        n.widx  = 2'd0;
                        n.state = S_FETCH;
                    end
                end
            end
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = q.base + AW'(q.widx) * AW'(WORD_B);
                if (mem_ack) begin
                    if (mem_err) begin
                        n.buserr = 1'b1;
                        n.run    = 1'b0;
                        n.state  = S_IDLE;
                    end else begin
                        case (q.widx)
                            2'd0: n.nxt = mem_rdata;
                            2'd1: n.src = mem_rdata;
                            2'd2: n.tgt = mem_rdata;
                            default: begin
                                n.cmd = mem_rdata;
                                n.len = mem_rdata[LEN_W-1:0];
                            end
                        endcase
                        n.widx  = q.widx + 2'd1;
                        n.state = !q.run ? S_IDLE :
                                  (q.widx == 2'd3) ? S_LAUNCH : S_FETCH;
                    end
                end
            end
            S_LAUNCH: begin
                if (start_en) n.start_st = 1'b1;
                n.burst = '0;
                n.state = (q.len == '0) ? S_FINISH : S_WAIT;
            end
            S_WAIT: begin
                if (!q.run)
                    n.state = S_IDLE;
                else if (!flow_on || dreq)
                    n.state = S_RD;
            end
            S_RD: begin
                mem_req  = 1'b1;
                mem_addr = q.src;
                mem_size = unit_size;
                if (mem_ack) begin
                    if (mem_err) begin
                        n.buserr = 1'b1;
                        n.run    = 1'b0;
                        n.state  = S_IDLE;
                    end else begin
                        n.data  = mem_rdata;
                        n.state = q.run ? S_WR : S_IDLE;
                    end
                end
            end
            S_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = q.tgt;
                mem_size = unit_size;
                if (mem_ack) begin
                    if (mem_err) begin
                        n.buserr = 1'b1;
                        n.run    = 1'b0;
                        n.state  = S_IDLE;
                    end else begin
                        if (inc_src) n.src = q.src + AW'(unit_bytes);
                        if (inc_tgt) n.tgt = q.tgt + AW'(unit_bytes);
                        n.len   = len_after;
                        n.burst = burst_after;
                        if (!q.run) begin
                            n.state = S_IDLE;
                        end else if (len_after == '0) begin
                            n.state = S_FINISH;
                        end else if (burst_after >= burst_bytes) begin
                            n.burst = '0;
                            n.state = S_WAIT;
                        end else begin
                            n.state = S_RD;
                        end
                    end
                end
            end
            S_FINISH: begin
                if (end_en) n.end_st = 1'b1;
                if (q.nodesc || q.nxt[0] || !q.run) begin
                    n.run   = 1'b0;
                    n.state = S_IDLE;
                end else begin
                    n.base  = {q.nxt[AW-1:4], 4'h0};
                    n.widx  = 2'd0;
                    n.state = S_FETCH;
                end
            end
            default: n.state = S_IDLE;
        endcase

        // control word write
        if (cfg_we && cfg_addr == A_CSR) begin
            if (!cfg_wdata[CSR_RUN])
                n.run = 1'b0;
            else if (q.state == S_IDLE && !q.run)
                n.run = 1'b1;
            n.nodesc  = cfg_wdata[CSR_NODESC];
            n.stopirq = cfg_wdata[CSR_STOPEN];
        end

        // descriptor registers accept writes only while fully stopped
        if (cfg_we && q.state == S_IDLE && !q.run) begin
            case (cfg_addr)
                A_NXT: n.nxt = cfg_wdata;
                A_SRC: n.src = cfg_wdata;
                A_TGT: n.tgt = cfg_wdata;
                A_CMD: n.cmd = cfg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
        end else begin
            q <= n;
        end
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R8
    buserr_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_err) |=> (stopped && !q.run && q.buserr));

    // R6
    buserr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.buserr |-> irq);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> !mem_req);

    // R4
    flow_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_WAIT && flow_on && !dreq) |=> !mem_req);
endmodule

// File: tb/dmach_engine_bench.sv
module dmach_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        dreq = 1'b0;
    logic        irq;

    always #5 clk = ~clk;

    dmach_engine u_dmach_engine (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_size(mem_size), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .dreq(dreq), .irq(irq)
    );

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
        logic [1:0]  s;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] mem [0:255];
    int          n_checks = 0;
    int          n_fail = 0;
    int          wr_seen = 0;
    int          acc_cnt = 0;
    int          cyc = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model: one-cycle acknowledge, error above 0x1000
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            acc_cnt++;
            if (mem_addr >= 32'h1000) begin
                mem_err <= 1'b1;
            end else begin
                mem_err <= 1'b0;
                if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[9:2]];
            end
        end else begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_we && mem_ack && !mem_err) begin
            wr_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected write", mem_addr, 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(mem_addr == e.a, "R3 write address", mem_addr, e.a);
                check(mem_wdata == e.d, "R3 write data", mem_wdata, e.d);
                check(mem_size == e.s, "R3 write size", {30'd0, mem_size}, {30'd0, e.s});
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic push_copy(input logic [31:0] s0, input logic [31:0] t0, input int len,
                             input int wb, input bit inc_s, input bit inc_t);
        logic [31:0] s, t;
        int          rem, u;
        exp_t        e;
        s = s0; t = t0; rem = len;
        while (rem > 0) begin
            u = (rem >= wb) ? wb : ((rem >= 2) ? 2 : 1);
            e.a = t;
            e.d = mem[s[9:2]];
            e.s = (u == 4) ? 2'd2 : ((u == 2) ? 2'd1 : 2'd0);
            exp_q.push_back(e);
            if (inc_s) s = s + u;
            if (inc_t) t = t + u;
            rem = rem - u;
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] nx, input logic [31:0] s,
                            input logic [31:0] t, input logic [31:0] c);
        mem[at[9:2]]     = nx;
        mem[at[9:2] + 1] = s;
        mem[at[9:2] + 2] = t;
        mem[at[9:2] + 3] = c;
    endtask

    task automatic wait_run_clear(input string tag);
        logic [31:0] v;
        int          k;
        k = 0;
        v = 32'h8000_0000;
        while (v[31] && k < 3000) begin
            reg_rd(3'd0, v);
            k++;
        end
        check(!v[31], tag, v, 32'd0);
    endtask

    task automatic wait_cycles(input int c);
        for (int i = 0; i < c; i++) @(negedge clk);
    endtask

    // command bit helpers
    localparam logic [31:0] C_INCS = 32'h8000_0000;
    localparam logic [31:0] C_INCT = 32'h4000_0000;
    localparam logic [31:0] C_FLOWS = 32'h2000_0000;
    localparam logic [31:0] C_STIE = 32'h0040_0000;
    localparam logic [31:0] C_ENIE = 32'h0020_0000;

    initial begin
        logic [31:0] v;
        int          w0, a0;
        for (int i = 0; i < 256; i++) mem[i] = 32'h5A00_0000 | (i * 32'h0001_0003);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_rd(3'd0, v);
        check(v == 32'h0000_0008, "R1 reset csr", v, 32'h8);
        check(irq == 1'b0, "R1 reset irq", {31'd0, irq}, 32'd0);

        // R2 two-descriptor chain, R5 start/end status
        put_desc(32'h100, 32'h120, 32'h200, 32'h300,
                 C_INCS | C_INCT | C_STIE | 32'h0001_C000 | 32'd16);
        put_desc(32'h120, 32'h1, 32'h240, 32'h340,
                 C_INCS | C_INCT | C_ENIE | 32'h0002_C000 | 32'd8);
        push_copy(32'h200, 32'h300, 16, 4, 1, 1);
        push_copy(32'h240, 32'h340, 8, 4, 1, 1);
        reg_wr(3'd1, 32'h100);
        reg_wr(3'd0, 32'h8000_0000);
        wait_run_clear("R2 chain completes");
        reg_rd(3'd0, v);
        check(v == 32'h0000_000E, "R2 R5 csr after chain", v, 32'hE);
        check(irq == 1'b1, "R6 irq on status", {31'd0, irq}, 32'd1);
        reg_rd(3'd2, v);
        check(v == 32'h248, "R3 source advanced", v, 32'h248);
        reg_rd(3'd3, v);
        check(v == 32'h348, "R3 target advanced", v, 32'h348);
        reg_rd(3'd1, v);
        check(v == 32'h1, "R2 next loaded from chain", v, 32'h1);
        check(exp_q.size() == 0, "R2 all writes seen", exp_q.size(), 0);

        // R5 write-one-to-clear
        reg_wr(3'd0, 32'h0000_0007);
        reg_rd(3'd0, v);
        check(v == 32'h0000_0008, "R5 w1c clears", v, 32'h8);
        check(irq == 1'b0, "R6 irq after clear", {31'd0, irq}, 32'd0);

        // R7 direct mode, R3 width 2, odd length, fixed source
        reg_wr(3'd2, 32'h200);
        reg_wr(3'd3, 32'h380);
        reg_wr(3'd4, C_INCT | 32'h0000_8000 | 32'd5);
        push_copy(32'h200, 32'h380, 5, 2, 0, 1);
        a0 = acc_cnt;
        reg_wr(3'd0, 32'hC000_0000);
        wait_run_clear("R7 direct run completes");
        reg_rd(3'd0, v);
        check(v == 32'h4000_0008, "R7 csr after direct", v, 32'h4000_0008);
        check(acc_cnt - a0 == 6, "R7 no fetch accesses", acc_cnt - a0, 6);
        check(exp_q.size() == 0, "R7 all writes seen", exp_q.size(), 0);
        reg_wr(3'd0, 32'h0);

        // R4 flow pacing, R10 frozen registers, R12 request bit
        put_desc(32'h140, 32'h1, 32'h200, 32'h3C0,
                 C_INCS | C_INCT | C_FLOWS | C_ENIE | 32'h0001_C000 | 32'd16);
        reg_wr(3'd1, 32'h140);
        w0 = wr_seen;
        reg_wr(3'd0, 32'h8000_0000);
        wait_cycles(40);
        check(wr_seen == w0, "R4 no write without dreq", wr_seen, w0);
        reg_rd(3'd0, v);
        check(v == 32'h8000_0000, "R4 running and waiting", v, 32'h8000_0000);
        reg_wr(3'd2, 32'h0000_DEAD);
        reg_rd(3'd2, v);
        check(v == 32'h200, "R10 source write ignored", v, 32'h200);
        push_copy(32'h200, 32'h3C0, 16, 4, 1, 1);
        dreq = 1'b1;
        reg_rd(3'd0, v);
        check(v[8] == 1'b1, "R12 request bit", v, 32'h100);
        wait_run_clear("R4 paced run completes");
        dreq = 1'b0;
        check(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);
        reg_rd(3'd0, v);
        check(v == 32'h0000_000C, "R5 end bit after paced run", v, 32'hC);
        reg_wr(3'd0, 32'h0000_0007);

        // R9 clearing run halts a waiting channel
        put_desc(32'h1A0, 32'h1, 32'h200, 32'h3E0,
                 C_INCS | C_INCT | C_FLOWS | C_ENIE | 32'h0001_C000 | 32'd16);
        reg_wr(3'd1, 32'h1A0);
        w0 = wr_seen;
        reg_wr(3'd0, 32'h8000_0000);
        wait_cycles(20);
        reg_wr(3'd0, 32'h0);
        wait_cycles(3);
        reg_rd(3'd0, v);
        check(v == 32'h0000_0008, "R9 halted by run clear", v, 32'h8);
        check(wr_seen == w0, "R9 no data moved", wr_seen, w0);

        // R11 stop flag at start
        reg_wr(3'd1, 32'h1);
        a0 = acc_cnt;
        reg_wr(3'd0, 32'h8000_0000);
        wait_cycles(4);
        reg_rd(3'd0, v);
        check(v == 32'h0000_0008, "R11 run drops on stop flag", v, 32'h8);
        check(acc_cnt == a0, "R11 no memory access", acc_cnt, a0);

        // R8 bus error on data read
        put_desc(32'h160, 32'h1, 32'h2000, 32'h300, C_INCS | C_INCT | 32'h0000_C000 | 32'd4);
        reg_wr(3'd1, 32'h160);
        w0 = wr_seen;
        reg_wr(3'd0, 32'h8000_0000);
        wait_run_clear("R8 error stops run");
        reg_rd(3'd0, v);
        check(v == 32'h0000_0009, "R8 bus error bit", v, 32'h9);
        check(irq == 1'b1, "R8 irq on error", {31'd0, irq}, 32'd1);
        check(wr_seen == w0, "R8 no write after error", wr_seen, w0);
        reg_wr(3'd0, 32'h0000_0001);

        // R3 zero length descriptor
        put_desc(32'h180, 32'h1, 32'h200, 32'h300, C_ENIE | 32'd0);
        reg_wr(3'd1, 32'h180);
        w0 = wr_seen;
        reg_wr(3'd0, 32'h8000_0000);
        wait_run_clear("R3 zero length completes");
        reg_rd(3'd0, v);
        check(v == 32'h0000_000C, "R3 zero length ends", v, 32'hC);
        check(wr_seen == w0, "R3 zero length moves nothing", wr_seen, w0);
        reg_wr(3'd0, 32'h0000_0007);

        // R6 stop interrupt
        reg_wr(3'd0, 32'h2000_0000);
        @(negedge clk);
        check(irq == 1'b1, "R6 stop interrupt", {31'd0, irq}, 32'd1);
        reg_wr(3'd0, 32'h0);
        @(negedge clk);
        check(irq == 1'b0, "R6 stop interrupt off", {31'd0, irq}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule